// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block produces the SCL and SDA line levels of an I2C master from an internal operating clock. A bit-level shifter above it asks for one bus event at a time: a start, a repeated start, a stop, or a single bit slot. The block plays that event as a short sequence of line phases, each one held for a programmed number of clocks. When the last phase has run it leaves the lines in the event's final state and raises a one-cycle done pulse.

Four counts set the timing: the full SCL period, the part of it that SCL spends low, the setup time SCL stays high before SDA moves for a repeated start or a stop, and the delay after SCL falls before new data is put on SDA. The counts are taken in only while the run enable is low. At that time the bus is idle, so a reload can never bend a waveform that is already in progress. Byte framing, acknowledge handling and data buffering belong to the shifter and are not part of this block.

Top module: `i2c_bus_timer`

## Requirements
- R1: While `rst_n` is low, or after any clock edge at which `run_en` was low, `scl_o` and `sda_o` are 1 (released) and `done_o` is 0. Any event in progress is abandoned, and a request seen while `run_en` is low is dropped.
- R2: The four count inputs are captured on every clock edge at which `run_en` is low, and only then. A change to them while `run_en` stays high has no effect on timing.
- R3: The effective period is the period count, raised to 3 if it is smaller than 3. The effective low time is the low count limited to the range 2 up to (effective period − 1). The high time is the effective period minus the effective low time.
- R4: The effective setup count is the setup input, raised to 1 if it is 0. The effective data delay is the data-setup input limited to the range 1 up to (effective low − 1).
- R5: `req_kind` is encoded as 0 = start, 1 = repeated start, 2 = stop, 3 = bit slot. A request (`req_stb` = 1) is accepted at a clock edge where the block is idle and `run_en` is high. The first phase shows on the lines right after that edge.
- R6: Start: SCL=1 and SDA=0 for setup clocks. The lines then end at SCL=0, SDA=0.
- R7: Repeated start: SCL=0 and SDA=1 for low clocks, then SCL=1 and SDA=1 for setup clocks, then SCL=1 and SDA=0 for setup clocks. The lines then end at SCL=0, SDA=0.
- R8: Stop: SCL=0 and SDA=0 for low clocks, then SCL=1 and SDA=0 for setup clocks. The lines then end at SCL=1, SDA=1.
- R9: Bit slot with value `req_bit` (captured at acceptance): SCL=0 with SDA unchanged for data-delay clocks, then SCL=0 and SDA=bit for (low − data delay) clocks, then SCL=1 and SDA=bit for high clocks. The lines then end at SCL=0, SDA=bit. SDA never changes while SCL is high inside a bit slot.
- R10: `done_o` is high for exactly one cycle, in the first cycle in which the final line state is shown. Requests that arrive while an event is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Normal-operation enable; low holds the bus idle and loads the counts |
| cyc_cnt | input | CNT_W | SCL period in clocks |
| low_cnt | input | CNT_W | SCL low time in clocks |
| rsu_cnt | input | CNT_W | Repeated-start/stop setup time in clocks |
| dsu_cnt | input | CNT_W | Delay from SCL fall to new SDA data, in clocks |
| req_stb | input | 1 | Event request strobe |
| req_kind | input | 2 | Event type (see R5) |
| req_bit | input | 1 | Data value for a bit slot |
| scl_o | output | 1 | SCL level to drive (1 = released) |
| sda_o | output | 1 | SDA level to drive (1 = released) |
| done_o | output | 1 | One-cycle pulse when an event has finished |

## Verification
A request that is present at clock edge k changes the lines right after edge k. Each phase of length n then holds for exactly n edges. The final state, together with done, appears after edge k plus the sum of the phase lengths. So a request driven at one falling edge produces done on the falling edge numbered (sum + 1) after it. The bench keeps a queue-based model of the phase list, steps it on every rising edge and compares all three outputs on every falling edge. Separate checks count falling edges from the request to done and compare the count with that sum + 1, which is worked out by hand from the counts in the requirements.

// File: rtl/i2c_tim_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C bus timing generator.
// Assumes: event codes are fixed, since the shifter above decodes them.
package i2c_tim_pkg;

    // Event kinds, encoded as the requester drives them
    typedef enum logic [1:0] {
        EV_START   = 2'd0,
        EV_RESTART = 2'd1,
        EV_STOP    = 2'd2,
        EV_BIT     = 2'd3
    } ev_kind_e;

    // Pair of line levels; 1 means released (pulled high)
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/i2c_tim_cfg.sv
`timescale 1ns/1ps
// Count capture and clamping.
// Captures the four timing counts while the run enable is low and
// derives effective phase lengths that are always at least one clock.
// Assumes: CW >= 3 so the minimum period fits.
module i2c_tim_cfg #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] cyc_in,
    input  logic [CW-1:0] low_in,
    input  logic [CW-1:0] rsu_in,
    input  logic [CW-1:0] dsu_in,
    output logic [CW-1:0] low_e,
    output logic [CW-1:0] high_e,
    output logic [CW-1:0] su_e,
    output logic [CW-1:0] ds_e,
    output logic [CW-1:0] lmd_e
);

    localparam logic [CW-1:0] MIN_CYC = CW'(3);
    localparam logic [CW-1:0] MIN_LOW = CW'(2);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic [CW-1:0] sh_cyc, sh_low, sh_rsu, sh_dsu;
    logic [CW-1:0] cyc_e;

    // Shadow copies follow the inputs only while the bus is held idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cyc <= '0;
            sh_low <= '0;
            sh_rsu <= '0;
            sh_dsu <= '0;
        end else if (!run_en) begin
            sh_cyc <= cyc_in;
            sh_low <= low_in;
            sh_rsu <= rsu_in;
            sh_dsu <= dsu_in;
        end
    end

    // Clamp period and low time so both SCL halves last at least one clock
    always_comb begin
        cyc_e = (sh_cyc < MIN_CYC) ? MIN_CYC : sh_cyc;
        if (sh_low < MIN_LOW)      low_e = MIN_LOW;
        else if (sh_low >= cyc_e)  low_e = cyc_e - ONE;
        else                       low_e = sh_low;
        high_e = cyc_e - low_e;
    end

    // Clamp setup and data delay; data must move while SCL is still low
    always_comb begin
        su_e = (sh_rsu == '0) ? ONE : sh_rsu;
        if (sh_dsu == '0)          ds_e = ONE;
        else if (sh_dsu >= low_e)  ds_e = low_e - ONE;
        else                       ds_e = sh_dsu;
        lmd_e = low_e - ds_e;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en) && $past(rst_n)) |->
            ($stable(sh_cyc) && $stable(sh_low) && $stable(sh_rsu) && $stable(sh_dsu))); // R2

endmodule

// File: rtl/i2c_tim_seq.sv
`timescale 1ns/1ps
// Phase table.
// For an event kind and a phase index, gives the line levels and length
// of that phase, the index of the last phase and the final line state.
// Assumes: all lengths it receives are already clamped to >= 1.
module i2c_tim_seq
    import i2c_tim_pkg::*;
#(
    parameter int CW = 12
) (
    input  ev_kind_e      kind,
    input  logic [1:0]    idx,
    input  logic          bit_val,
    input  logic          cur_sda,
    input  logic [CW-1:0] low_e,
    input  logic [CW-1:0] high_e,
    input  logic [CW-1:0] su_e,
    input  logic [CW-1:0] ds_e,
    input  logic [CW-1:0] lmd_e,
    output line_t         seg_line,
    output logic [CW-1:0] seg_len,
    output logic [1:0]    last_idx,
    output line_t         fin_line
);

    // Look up one phase of the selected event
    always_comb begin
        seg_line = LINE_IDLE;
        seg_len  = su_e;
        last_idx = 2'd0;
        fin_line = LINE_IDLE;
        unique case (kind)
            EV_START: begin
                last_idx = 2'd0;
                fin_line = '{scl: 1'b0, sda: 1'b0};
                seg_line = '{scl: 1'b1, sda: 1'b0};
                seg_len  = su_e;
            end
            EV_RESTART: begin
                last_idx = 2'd2;
                fin_line = '{scl: 1'b0, sda: 1'b0};
                case (idx)
                    2'd0: begin
                        seg_line = '{scl: 1'b0, sda: 1'b1};
                        seg_len  = low_e;
                    end
                    2'd1: begin
                        seg_line = '{scl: 1'b1, sda: 1'b1};
                        seg_len  = su_e;
                    end
                    default: begin
                        seg_line = '{scl: 1'b1, sda: 1'b0};
                        seg_len  = su_e;
                    end
                endcase
            end
            EV_STOP: begin
                last_idx = 2'd1;
                fin_line = '{scl: 1'b1, sda: 1'b1};
                if (idx == 2'd0) begin
                    seg_line = '{scl: 1'b0, sda: 1'b0};
                    seg_len  = low_e;
                end else begin
                    seg_line = '{scl: 1'b1, sda: 1'b0};
                    seg_len  = su_e;
                end
            end
            EV_BIT: begin
                last_idx = 2'd2;
                fin_line = '{scl: 1'b0, sda: bit_val};
                case (idx)
                    2'd0: begin
                        seg_line = '{scl: 1'b0, sda: cur_sda};
                        seg_len  = ds_e;
                    end
                    2'd1: begin
                        seg_line = '{scl: 1'b0, sda: bit_val};
                        seg_len  = lmd_e;
                    end
                    default: begin
                        seg_line = '{scl: 1'b1, sda: bit_val};
                        seg_len  = high_e;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/i2c_tim_engine.sv
`timescale 1ns/1ps
// Phase engine.
// Accepts one request when idle, steps through the phases of that event
// with a down-counter, then shows the final line state with a done pulse.
// Assumes: the effective lengths from i2c_tim_cfg never change while run.
module i2c_tim_engine
    import i2c_tim_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          req,
    input  ev_kind_e      req_kind,
    input  logic          req_bit,
    input  logic [CW-1:0] low_e,
    input  logic [CW-1:0] high_e,
    input  logic [CW-1:0] su_e,
    input  logic [CW-1:0] ds_e,
    input  logic [CW-1:0] lmd_e,
    output line_t         line_o,
    output logic          done_o
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic          busy_q;
    ev_kind_e      kind_q;
    logic [1:0]    step_q;
    logic [CW-1:0] cnt_q;
    logic          bit_q;
    line_t         line_q;
    logic          done_q;

    ev_kind_e      kind_sel;
    logic [1:0]    idx_sel;
    logic          bit_sel;
    line_t         seg_line;
    logic [CW-1:0] seg_len;
    logic [1:0]    last_idx;
    line_t         fin_line;

    // Look at the new request when idle, at the running event otherwise
    always_comb begin
        kind_sel = busy_q ? kind_q : req_kind;
        idx_sel  = busy_q ? (step_q + 2'd1) : 2'd0;
        bit_sel  = busy_q ? bit_q : req_bit;
    end

    i2c_tim_seq #(.CW(CW)) u_seq (
        .kind     (kind_sel),
        .idx      (idx_sel),
        .bit_val  (bit_sel),
        .cur_sda  (line_q.sda),
        .low_e    (low_e),
        .high_e   (high_e),
        .su_e     (su_e),
        .ds_e     (ds_e),
        .lmd_e    (lmd_e),
        .seg_line (seg_line),
        .seg_len  (seg_len),
        .last_idx (last_idx),
        .fin_line (fin_line)
    );

    // Accept, count down, advance phases and finish events
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            busy_q <= 1'b0;
            kind_q <= EV_START;
            step_q <= 2'd0;
            cnt_q  <= '0;
            bit_q  <= 1'b0;
            line_q <= LINE_IDLE;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req) begin
                    busy_q <= 1'b1;
                    kind_q <= req_kind;
                    bit_q  <= req_bit;
                    step_q <= 2'd0;
                    line_q <= seg_line;
                    cnt_q  <= seg_len - ONE;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - ONE;
            end else if (step_q == last_idx) begin
                busy_q <= 1'b0;
                line_q <= fin_line;
                done_q <= 1'b1;
            end else begin
                step_q <= step_q + 2'd1;
                line_q <= seg_line;
                cnt_q  <= seg_len - ONE;
            end
        end
    end

    assign line_o = line_q;
    assign done_o = done_q;

    AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (line_q.scl && line_q.sda && !done_q)); // R1
    AST_START_SDA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q == EV_START) |-> (line_q.scl && !line_q.sda)); // R6
    AST_STOP_LEAVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && kind_q == EV_STOP) |-> (line_q.scl && line_q.sda)); // R8
    AST_BIT_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q == EV_BIT && line_q.scl) |-> $stable(line_q.sda)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10
    AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && busy_q && cnt_q != '0) |=> (busy_q && kind_q == $past(kind_q))); // R10

endmodule

// File: rtl/i2c_bus_timer.sv
`timescale 1ns/1ps
// I2C bus timing generator, top level.
// Joins count capture and the phase engine and exposes line levels.
// Assumes: the requester waits for done before it issues the next event.
module i2c_bus_timer
    import i2c_tim_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] cyc_cnt,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] rsu_cnt,
    input  logic [CNT_W-1:0] dsu_cnt,
    input  logic             req_stb,
    input  logic [1:0]       req_kind,
    input  logic             req_bit,
    output logic             scl_o,
    output logic             sda_o,
    output logic             done_o
);

    logic [CNT_W-1:0] low_e, high_e, su_e, ds_e, lmd_e;
    line_t            line;

    i2c_tim_cfg #(.CW(CNT_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_en),
        .cyc_in (cyc_cnt),
        .low_in (low_cnt),
        .rsu_in (rsu_cnt),
        .dsu_in (dsu_cnt),
        .low_e  (low_e),
        .high_e (high_e),
        .su_e   (su_e),
        .ds_e   (ds_e),
        .lmd_e  (lmd_e)
    );

    i2c_tim_engine #(.CW(CNT_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .req      (req_stb),
        .req_kind (ev_kind_e'(req_kind)),
        .req_bit  (req_bit),
        .low_e    (low_e),
        .high_e   (high_e),
        .su_e     (su_e),
        .ds_e     (ds_e),
        .lmd_e    (lmd_e),
        .line_o   (line),
        .done_o   (done_o)
    );

    assign scl_o = line.scl;
    assign sda_o = line.sda;

endmodule

// File: tb/test_i2c_bus_timer.sv
`timescale 1ns/1ps
// Bench: a behavioural phase-queue model compared on every falling edge,
// plus hand-computed request-to-done cycle counts.
module test_i2c_bus_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [11:0] cyc_cnt = 12'd20, low_cnt = 12'd10, rsu_cnt = 12'd6, dsu_cnt = 12'd2;
    logic        req_stb = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_bit = 1'b0;
    logic        scl_o, sda_o, done_o;

    int total = 0;
    int bad = 0;
    string cur_tag = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    i2c_bus_timer #(.CNT_W(12)) i_i2c_bus_timer (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cyc_cnt(cyc_cnt), .low_cnt(low_cnt), .rsu_cnt(rsu_cnt), .dsu_cnt(dsu_cnt),
        .req_stb(req_stb), .req_kind(req_kind), .req_bit(req_bit),
        .scl_o(scl_o), .sda_o(sda_o), .done_o(done_o)
    );

    // Reference model state
    int m_c, m_l, m_s, m_d, m_rem;
    bit m_busy, m_fs, m_fd;
    bit exp_scl = 1, exp_sda = 1, exp_done = 0;
    bit q_scl[$];
    bit q_sda[$];
    int q_len[$];

    task automatic push(input bit s, input bit d, input int n);
        q_scl.push_back(s); q_sda.push_back(d); q_len.push_back(n);
    endtask

    task automatic pop();
        exp_scl = q_scl.pop_front(); exp_sda = q_sda.pop_front(); m_rem = q_len.pop_front();
    endtask

    task automatic go_idle();
        q_scl.delete(); q_sda.delete(); q_len.delete();
        m_busy = 0; exp_scl = 1; exp_sda = 1; exp_done = 0;
    endtask

    // Model step on each rising edge (reads only bench-driven inputs)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_c = 0; m_l = 0; m_s = 0; m_d = 0;
            go_idle();
        end else if (!run_en) begin
            m_c = cyc_cnt; m_l = low_cnt; m_s = rsu_cnt; m_d = dsu_cnt;
            go_idle();
        end else begin
            exp_done = 0;
            if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    if (q_len.size() == 0) begin
                        exp_scl = m_fs; exp_sda = m_fd; exp_done = 1; m_busy = 0;
                    end else pop();
                end
            end else if (req_stb) begin
                int c, l, h, s, d;
                c = (m_c < 3) ? 3 : m_c;
                l = (m_l < 2) ? 2 : ((m_l >= c) ? c - 1 : m_l);
                h = c - l;
                s = (m_s == 0) ? 1 : m_s;
                d = (m_d == 0) ? 1 : ((m_d >= l) ? l - 1 : m_d);
                case (req_kind)
                    2'd0: begin push(1, 0, s); m_fs = 0; m_fd = 0; end
                    2'd1: begin push(0, 1, l); push(1, 1, s); push(1, 0, s); m_fs = 0; m_fd = 0; end
                    2'd2: begin push(0, 0, l); push(1, 0, s); m_fs = 1; m_fd = 1; end
                    default: begin
                        push(0, exp_sda, d); push(0, req_bit, l - d); push(1, req_bit, h);
                        m_fs = 0; m_fd = req_bit;
                    end
                endcase
                pop();
                m_busy = 1;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (scl_o !== exp_scl || sda_o !== exp_sda || done_o !== exp_done) begin
                bad++;
                $display("FAIL %s cycle compare: actual scl=%0b sda=%0b done=%0b expected scl=%0b sda=%0b done=%0b",
                         cur_tag, scl_o, sda_o, done_o, exp_scl, exp_sda, exp_done);
            end
        end
    end

    task automatic check(input string tag, input int act, input int expv, input string what);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Issue one event and count falling edges to done; poke>0 injects a stray request
    task automatic run_ev(input int kind, input bit b, input int exp_cyc, input string tag, input int poke);
        int i;
        cur_tag = tag;
        req_stb = 1; req_kind = kind[1:0]; req_bit = b;
        i = 0;
        do begin
            @(negedge clk);
            req_stb = 0;
            i++;
            if (poke > 0 && i == poke) begin req_stb = 1; req_kind = 2'd2; req_bit = ~b; end
        end while (!done_o && i < 5000);
        check(tag, i, exp_cyc + 1, "request-to-done falling edges");
    endtask

    task automatic set_counts(input int c, input int l, input int s, input int d);
        cyc_cnt = c[11:0]; low_cnt = l[11:0]; rsu_cnt = s[11:0]; dsu_cnt = d[11:0];
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {scl_o, sda_o, done_o}, 3'b110, "lines in reset");
        rst_n = 1;
        @(negedge clk);
        run_en = 1;
        @(negedge clk);

        // C=20 L=10 S=6 D=2 -> low 10, high 10, setup 6, delay 2
        run_ev(0, 0, 6,  "R6", 0);
        run_ev(3, 1, 20, "R9", 0);
        run_ev(3, 0, 20, "R9", 0);
        run_ev(3, 1, 20, "R9", 0);
        run_ev(1, 0, 22, "R7", 0);
        run_ev(3, 0, 20, "R5", 0);
        run_ev(2, 0, 16, "R8", 0);
        check("R8", {scl_o, sda_o}, 2'b11, "lines after stop");

        // R10: stray request mid-event is ignored
        run_ev(1, 0, 22, "R10", 4);
        run_ev(2, 0, 16, "R10", 0);

        // R2: count change while running has no effect
        set_counts(60, 30, 12, 4);
        run_ev(0, 0, 6,  "R2", 0);
        run_ev(3, 1, 20, "R2", 0);
        run_ev(2, 0, 16, "R2", 0);
        run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
        run_ev(3, 0, 60, "R2", 0);
        run_ev(2, 0, 42, "R2", 0);

        // R3/R4: lower clamps: C=1 L=0 S=0 D=0 -> period 3, low 2, high 1, setup 1, delay 1
        set_counts(1, 0, 0, 0);
        run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
        run_ev(0, 0, 1, "R4", 0);
        run_ev(3, 1, 3, "R3", 0);
        run_ev(1, 0, 4, "R4", 0);
        run_ev(2, 0, 3, "R3", 0);

        // R3/R4: upper clamps: C=10 L=50 S=4 D=20 -> low 9, high 1, delay 8
        set_counts(10, 50, 4, 20);
        run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
        run_ev(3, 0, 10, "R3", 0);
        run_ev(3, 1, 10, "R4", 0);
        run_ev(2, 0, 13, "R3", 0);

        // R1: disable mid-event drops it and releases the lines
        set_counts(20, 10, 6, 2);
        run_en = 0; @(negedge clk); run_en = 1; @(negedge clk);
        cur_tag = "R1";
        req_stb = 1; req_kind = 2'd1; req_bit = 0;
        @(negedge clk); req_stb = 0;
        repeat (3) @(negedge clk);
        run_en = 0;
        req_stb = 1; req_kind = 2'd3;
        @(negedge clk);
        check("R1", {scl_o, sda_o, done_o}, 3'b110, "lines after disable");
        req_stb = 0; run_en = 1;
        repeat (30) @(negedge clk);
        check("R1", {scl_o, sda_o, done_o}, 3'b110, "no pending event after re-enable");
        run_ev(0, 0, 6, "R6", 0);
        run_ev(2, 0, 16, "R8", 0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule